// File: doc/BRIEF.md
# Multi-Port Physical Register Free List

This block keeps the pool of physical register IDs that nothing currently references. A rename stage draws IDs from it, and commit logic gives them back. The pool is a circular queue. The head pointer marks the next ID to hand out and the tail pointer marks where a returned ID goes. Up to `PORTS` IDs can leave and up to `PORTS` IDs can return in the same cycle.

The requester shows, each cycle, how many IDs it wants. The block always presents the `PORTS` entries starting at the head, so the requester can read the IDs before the grant is known. The grant is all-or-nothing: the whole request is honoured, or nothing is consumed.

After reset the queue holds every physical register that is not an initial architectural mapping. The initial mappings are physical registers `0 .. NUM_ARCH-1`, so the queue starts with `NUM_ARCH .. NUM_PHYS-1` in ascending order from the head. An ID re-enters the queue only when the owner returns it, which happens once a later write to the same architectural register has committed.

Top module: `preg_free_list`

## Requirements
- R1: While `rst` is high, at each rising clock edge the list resets. From the next edge `avail` equals `DEPTH = NUM_PHYS - NUM_ARCH`, and head entry `p` holds ID `NUM_ARCH + p`.
- R2: `alloc_ids` bits `[p*IDW +: IDW]` show, without waiting a clock, the entry `p` places after the head, for every `p < PORTS`.
- R3: `alloc_grant` is high exactly when `alloc_req <= PORTS` and `alloc_req <= avail`. A request of 0 is always granted and consumes nothing.
- R4: A granted request of k moves the head forward by k entries at the next edge. A refused request leaves the head and the list contents unchanged.
- R5: When `free_cnt = k <= PORTS`, free slots `0 .. k-1` are written in that order at the tail. They are handed out after all entries already in the queue.
- R6: At each edge `avail` becomes `avail - granted + freed`. IDs returned in a cycle cannot help a request in that same cycle.
- R7: The head and tail pointers wrap modulo `DEPTH`, so the hand-out order stays first-in-first-out across the wrap.
- R8: A `free_cnt` greater than `PORTS` is ignored completely: no entry is written and `avail` does not change.
- R9: `avail` never exceeds `DEPTH`.
- R10: No ID is handed out a second time unless it has been returned in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | CW = clog2(PORTS+1) | Number of IDs requested this cycle |
| alloc_grant | output | 1 | Request honoured in full this cycle |
| alloc_ids | output | PORTS*IDW | The `PORTS` entries starting at the head; slot p at bits [p*IDW +: IDW] |
| free_cnt | input | CW | Number of IDs returned this cycle |
| free_ids | input | PORTS*IDW | Returned IDs; slot p at bits [p*IDW +: IDW] |
| avail | output | CNTW = clog2(DEPTH+1) | IDs currently in the list |

## Verification
The bound checker watches several properties on every cycle:
- the reset value of the count (R1);
- the bound on the count (R9);
- the refusal of requests larger than the count (R3);
- the count-update arithmetic (R6), together with the ignoring of oversized returns (R8);
- the stability of the head window when nothing is granted or written (R4).

Other behaviours need the bench's scenarios and reference queue:
- the hand-out order of IDs across pointer wrap (R2, R5, R7);
- the refusal of a request that same-cycle frees would have covered (R6);
- the uniqueness of outstanding IDs (R10).

// File: rtl/fl_pkg.sv
package fl_pkg;

    parameter int FL_NUM_PHYS = 64;
    parameter int FL_NUM_ARCH = 16;
    parameter int FL_PORTS    = 6;

    // modular add, valid while p < d and k <= d
    function automatic int unsigned fl_wrap(input int unsigned p,
                                            input int unsigned k,
                                            input int unsigned d);
        int unsigned s;
        s = p + k;
        return (s >= d) ? s - d : s;
    endfunction

endpackage

// File: rtl/fl_counter.sv
module fl_counter #(
    parameter int DEPTH = 48,
    parameter int PORTS = 6,
    parameter int CW    = 3,
    parameter int CNTW  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   req,
    input  logic [CW-1:0]   ret,
    output logic            grant,
    output logic [CW-1:0]   take_amt,
    output logic [CW-1:0]   give_amt,
    output logic [CNTW-1:0] avail
);
    logic [CNTW-1:0] cnt_q;

    always_comb begin
        grant    = (32'(req) <= 32'(PORTS)) && (CNTW'(req) <= cnt_q);
        take_amt = grant ? req : '0;
        give_amt = (32'(ret) <= 32'(PORTS)) ? ret : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CNTW'(DEPTH);
        else     cnt_q <= cnt_q - CNTW'(take_amt) + CNTW'(give_amt);
    end

    assign avail = cnt_q;
endmodule

// File: rtl/fl_pointer.sv
module fl_pointer #(
    parameter int DEPTH = 48,
    parameter int PTRW  = 6,
    parameter int CW    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   adv,
    output logic [PTRW-1:0] ptr
);
    import fl_pkg::*;

    logic [PTRW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= PTRW'(fl_wrap(32'(ptr_q), 32'(adv), DEPTH));
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/fl_store.sv
module fl_store #(
    parameter int DEPTH = 48,
    parameter int PORTS = 6,
    parameter int IDW   = 6,
    parameter int PTRW  = 6,
    parameter int CW    = 3,
    parameter int BASE  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PTRW-1:0]       head,
    input  logic [PTRW-1:0]       tail,
    input  logic [CW-1:0]         wr_cnt,
    input  logic [PORTS*IDW-1:0]  wr_ids,
    output logic [PORTS*IDW-1:0]  rd_ids
);
    import fl_pkg::*;

    logic [IDW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= IDW'(BASE + i);
        end else begin
            for (int p = 0; p < PORTS; p++) begin
                if (p < int'(wr_cnt))
                    mem[PTRW'(fl_wrap(32'(tail), 32'(p), DEPTH))] <= wr_ids[p*IDW +: IDW];
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_ids[p*IDW +: IDW] = mem[PTRW'(fl_wrap(32'(head), 32'(p), DEPTH))];
    end
endmodule

// File: rtl/preg_free_list.sv
module preg_free_list #(
    parameter int NUM_PHYS = fl_pkg::FL_NUM_PHYS,
    parameter int NUM_ARCH = fl_pkg::FL_NUM_ARCH,
    parameter int PORTS    = fl_pkg::FL_PORTS,
    localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
    localparam int IDW     = $clog2(NUM_PHYS),
    localparam int PTRW    = $clog2(DEPTH),
    localparam int CW      = $clog2(PORTS + 1),
    localparam int CNTW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        alloc_req,
    output logic                 alloc_grant,
    output logic [PORTS*IDW-1:0] alloc_ids,
    input  logic [CW-1:0]        free_cnt,
    input  logic [PORTS*IDW-1:0] free_ids,
    output logic [CNTW-1:0]      avail
);
    logic [CW-1:0]   take_amt, give_amt;
    logic [PTRW-1:0] head, tail;

    fl_counter #(.DEPTH(DEPTH), .PORTS(PORTS), .CW(CW), .CNTW(CNTW)) u_cnt (
        .clk(clk), .rst(rst), .req(alloc_req), .ret(free_cnt),
        .grant(alloc_grant), .take_amt(take_amt), .give_amt(give_amt),
        .avail(avail)
    );

    fl_pointer #(.DEPTH(DEPTH), .PTRW(PTRW), .CW(CW)) u_head (
        .clk(clk), .rst(rst), .adv(take_amt), .ptr(head)
    );

    fl_pointer #(.DEPTH(DEPTH), .PTRW(PTRW), .CW(CW)) u_tail (
        .clk(clk), .rst(rst), .adv(give_amt), .ptr(tail)
    );

    fl_store #(.DEPTH(DEPTH), .PORTS(PORTS), .IDW(IDW), .PTRW(PTRW),
               .CW(CW), .BASE(NUM_ARCH)) u_store (
        .clk(clk), .rst(rst), .head(head), .tail(tail),
        .wr_cnt(give_amt), .wr_ids(free_ids), .rd_ids(alloc_ids)
    );
endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
    parameter int DEPTH = 48,
    parameter int PORTS = 6,
    parameter int IDW   = 6,
    parameter int CW    = 3,
    parameter int CNTW  = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CW-1:0]        alloc_req,
    input logic                 alloc_grant,
    input logic [PORTS*IDW-1:0] alloc_ids,
    input logic [CW-1:0]        free_cnt,
    input logic [CNTW-1:0]      avail
);
    logic [CNTW:0] took, gave;
    logic          writes;

    always_comb begin
        took   = alloc_grant ? (CNTW+1)'(alloc_req) : '0;
        writes = (free_cnt != '0) && (32'(free_cnt) <= 32'(PORTS));
        gave   = writes ? (CNTW+1)'(free_cnt) : '0;
    end

    // R1
    reset_count_chk: assert property (@(posedge clk)
        rst |=> avail == CNTW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        32'(avail) <= 32'(DEPTH));

    // R3
    refuse_short_chk: assert property (@(posedge clk) disable iff (rst)
        ((CNTW+1)'(alloc_req) > (CNTW+1)'(avail)) |-> !alloc_grant);

    // R6 R8
    count_update_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (CNTW+1)'(avail) == (CNTW+1)'($past(avail)) - $past(took) + $past(gave));

    // R4
    idle_window_chk: assert property (@(posedge clk) disable iff (rst)
        (took == '0 && !writes) |=> $stable(alloc_ids));
endmodule

bind preg_free_list fl_checker #(
    .DEPTH(DEPTH), .PORTS(PORTS), .IDW(IDW), .CW(CW), .CNTW(CNTW)
) u_fl_chk (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
    .alloc_ids(alloc_ids), .free_cnt(free_cnt), .avail(avail)
);

// File: tb/test_preg_free_list.sv
module test_preg_free_list;
    import fl_pkg::*;

    localparam int PORTS = FL_PORTS;
    localparam int NPHYS = FL_NUM_PHYS;
    localparam int NARCH = FL_NUM_ARCH;
    localparam int DEPTH = NPHYS - NARCH;
    localparam int IDW   = $clog2(NPHYS);
    localparam int CW    = $clog2(PORTS + 1);
    localparam int CNTW  = $clog2(DEPTH + 1);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [CW-1:0]        alloc_req = '0;
    logic                 alloc_grant;
    logic [PORTS*IDW-1:0] alloc_ids;
    logic [CW-1:0]        free_cnt = '0;
    logic [PORTS*IDW-1:0] free_ids = '0;
    logic [CNTW-1:0]      avail;

    always #4 clk = ~clk;

    preg_free_list i_preg_free_list (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
        .alloc_ids(alloc_ids), .free_cnt(free_cnt), .free_ids(free_ids),
        .avail(avail)
    );

    typedef struct {
        bit    grant;
        int    avail;
        int    req;
        int    nids;
        int    ids[PORTS];
        string tag;
    } exp_t;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    model_q[$];
    int    held_q[$];
    bit    out_dut[NPHYS];
    exp_t  exp_q[$];

    function automatic void chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endfunction

    task automatic step(input int req, input int nfree, input string tag,
                        input bit junk = 1'b0);
        exp_t e;
        int   fl[$];
        @(negedge clk);
        alloc_req = CW'(req);
        free_cnt  = CW'(nfree);
        free_ids  = '0;
        if (!junk) begin
            for (int k = 0; k < nfree; k++) begin
                fl.push_back(held_q.pop_front());
                free_ids[k*IDW +: IDW] = IDW'(fl[k]);
            end
        end else begin
            for (int k = 0; k < PORTS; k++) free_ids[k*IDW +: IDW] = IDW'(k);
        end
        e.grant = (req <= PORTS) && (req <= model_q.size());
        e.avail = model_q.size();
        e.req   = req;
        e.nids  = (model_q.size() < PORTS) ? model_q.size() : PORTS;
        for (int p = 0; p < e.nids; p++) e.ids[p] = model_q[p];
        e.tag = tag;
        exp_q.push_back(e);
        if (e.grant) begin
            for (int k = 0; k < req; k++) held_q.push_back(model_q.pop_front());
        end
        if (!junk) begin
            for (int k = 0; k < nfree; k++) model_q.push_back(fl[k]);
        end
    endtask

    // monitor: compares outputs well after the driver has settled inputs
    always @(negedge clk) begin
        exp_t e;
        int   id;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(alloc_grant == e.grant, "R3", {e.tag, " grant"}, int'(alloc_grant), int'(e.grant));
            chk(int'(avail) == e.avail, "R6", {e.tag, " avail"}, int'(avail), e.avail);
            chk(int'(avail) <= DEPTH, "R9", "avail bound", int'(avail), DEPTH);
            for (int p = 0; p < e.nids; p++) begin
                id = int'(alloc_ids[p*IDW +: IDW]);
                chk(id == e.ids[p], "R2", {e.tag, " head id"}, id, e.ids[p]);
            end
            if (alloc_grant) begin
                for (int p = 0; p < int'(alloc_req) && p < PORTS; p++) begin
                    id = int'(alloc_ids[p*IDW +: IDW]);
                    chk(!out_dut[id], "R10", "id handed out twice", id, -1);
                    out_dut[id] = 1'b1;
                end
            end
            if (int'(free_cnt) <= PORTS) begin
                for (int p = 0; p < int'(free_cnt); p++)
                    out_dut[int'(free_ids[p*IDW +: IDW])] = 1'b0;
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog (all R): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int r;
        int nf;
        int a0;
        for (int i = NARCH; i < NPHYS; i++) model_q.push_back(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(int'(avail) == DEPTH, "R1", "reset avail", int'(avail), DEPTH);
        chk(int'(alloc_ids[0 +: IDW]) == NARCH, "R1", "reset head id", int'(alloc_ids[0 +: IDW]), NARCH);

        step(0, 0, "R1");
        step(6, 0, "R4");
        step(3, 0, "R4");
        step(1, 0, "R2");
        step(7, 0, "R3");           // beyond the port count: refused
        step(0, 0, "R3");
        step(4, 2, "R5");
        step(0, 3, "R5");
        step(0, 0, "R5");

        // drain across the wrap point
        while (model_q.size() >= PORTS) step(PORTS, 0, "R7");
        r = model_q.size() + 1;
        step(r, PORTS, "R6");       // same-cycle frees must not rescue it
        step(r, 0, "R6");           // now enough entries
        step(model_q.size() <= PORTS ? model_q.size() : PORTS, 0, "R3");
        while (model_q.size() >= PORTS) step(PORTS, 0, "R7");
        step(model_q.size(), 0, "R3");
        step(1, 0, "R3");           // empty list refuses

        // oversized return is ignored
        a0 = model_q.size();
        step(0, 7, "R8", 1'b1);
        step(0, 0, "R8");
        @(negedge clk);
        #2;
        chk(int'(avail) == a0, "R8", "avail after ignored return", int'(avail), a0);

        while (held_q.size() > 0)
            step(0, held_q.size() < PORTS ? held_q.size() : PORTS, "R7");
        step(0, 0, "R9");

        repeat (400) begin
            r  = $urandom_range(0, PORTS);
            nf = $urandom_range(0, held_q.size() < PORTS ? held_q.size() : PORTS);
            step(r, nf, "R10");
        end
        step(0, 0, "R7");
        repeat (3) @(negedge clk);
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule